// File: doc/BRIEF.md
# Biphase Mark Message Transmitter

This block sends one power-negotiation message over a single shared configuration wire. Software or a controller first writes the message's 32-bit data objects, one word per cycle, into a small internal store. It then presents the 16-bit header and pulses `start`. The transmitter takes the wire and sends a fixed frame. The frame is a training preamble, then the header, then the stored objects in the order they were written, then a 32-bit checksum over the header and the objects. All fields go out least significant bit first.

Every bit is sent with biphase mark coding. The line always changes level at the start of a bit, and it changes a second time in the middle of the bit when the bit is a one. An internal divider splits each bit into two half-bit slots of `HALF_BIT_CYC` system clocks. The default of 333 cycles at 200 MHz gives about 300 kbit/s. The wire is shared in half duplex. For this reason the output enable is only raised while a frame is on the wire, and the block always hands the wire back at low level.

A 3-bit field in the header states how many objects follow. The block compares this field with the number of words actually written. It refuses to start on a mismatch, and it also refuses a start while a frame is in progress.

Top module: `bmc_msg_tx`

## Requirements
- R1: After reset and whenever no frame is being sent, `line_oe`, `line_o`, `busy` and `done` are all low.
- R2: Each half-bit slot lasts exactly `HALF_BIT_CYC` clocks. The line level toggles at the start of every bit, and toggles again at mid-bit only for a one. The first toggle of a frame goes from the idle low level to high, in the clock after `start` is sampled.
- R3: Bits on the wire come in this order: 64 preamble bits alternating 0,1,0,1 (starting with 0), then header bits 0 to 15, then each stored object's bits 0 to 31, with objects in write order.
- R4: The last 32 data bits are a CRC-32 taken over the header bits and object bits in wire order. It uses generator 0x04C11DB7 in reflected (LSB-first) form, a register preset to all ones, and an inverted result. The result is sent bit 0 first.
- R5: Header bits [14:12] give the object count (0 to 7). If this count differs from the number of words stored, `start` is refused: `start_err` is high for one cycle in the next clock, and the line stays released.
- R6: A `start` that arrives while `busy` is high is refused with a one-cycle `start_err` in the next clock. The frame in progress continues unchanged.
- R7: After the last CRC bit, one more bit period is sent. Its first half is at the toggled level and its second half is low. In the clock after that period, `line_oe` and `busy` fall and `done` is high for exactly one cycle.
- R8: Object writes while `busy` is high are ignored. Writes beyond seven stored words are ignored. Accepting a frame empties the store count, so the next message needs fresh writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| obj_wr | input | 1 | Store `obj_data` as the next data object |
| obj_data | input | 32 | Data object word |
| start | input | 1 | Request to send a frame with `header` |
| header | input | 16 | Message header, count field in bits [14:12] |
| line_o | output | 1 | Encoded line level |
| line_oe | output | 1 | Line driver enable, high only during a frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when the line is released |
| start_err | output | 1 | One-cycle pulse when a start was refused |

## Verification
Frames are sent with zero, one, two and seven objects. Payloads are all zeros, all ones and mixed words. A run of zeros shows only boundary toggles, so it exposes a missing or extra mid-bit toggle. A run of ones shows whether the mid-bit toggle is present. Mixed words expose errors in bit order, object order and CRC reflection. Frames with different lengths also move the final line level before the tail, so both the one-toggle and the two-toggle tail endings are tested. Directed cases cover a count mismatch, a start while busy, writes made during a frame, and an eighth and ninth write past the store limit.

// File: rtl/bmc_tx_pkg.sv
// Shared types and field widths for the biphase mark message transmitter.
// Assumes fixed header, object and checksum widths; counts are parameters of the top.
package bmc_tx_pkg;
    localparam int HDR_BITS = 16;
    localparam int OBJ_BITS = 32;
    localparam int CRC_BITS = 32;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_HDR,
        PH_OBJ,
        PH_CRC,
        PH_TAIL
    } phase_t;
endpackage

// File: rtl/tx_halfbit_timer.sv
// Half-bit timer: while run is high, emits a one-cycle tick every HALF_CYC clocks.
// Assumes HALF_CYC >= 2. The count restarts from zero each time run rises.
module tx_halfbit_timer #(
    parameter int HALF_CYC = 333
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Count system clocks within the current half-bit slot.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run)           cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/tx_obj_buffer.sv
// Object store: keeps up to MAX_OBJ words in write order and reports how many are held.
// Assumes the caller blocks writes while sending. clr empties the count, not the words.
module tx_obj_buffer #(
    parameter int MAX_OBJ = 7,
    parameter int WIDTH   = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [WIDTH-1:0]                   wr_data,
    input  logic                               clr,
    input  logic [$clog2(MAX_OBJ+1)-1:0]       rd_idx,
    output logic [WIDTH-1:0]                   rd_data,
    output logic [$clog2(MAX_OBJ+1)-1:0]       count
);
    localparam int IW = $clog2(MAX_OBJ + 1);
    localparam logic [IW-1:0] FULL = IW'(MAX_OBJ);

    logic [WIDTH-1:0] mem_q [MAX_OBJ];
    logic [IW-1:0]    cnt_q;
    logic             do_wr;

    assign do_wr = wr_en && !clr && (cnt_q < FULL);

    // Track the number of stored words; saturate at the store size.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr)   cnt_q <= '0;
        else if (do_wr) cnt_q <= cnt_q + 1'b1;
    end

    // Write the incoming word into the next free entry.
    always_ff @(posedge clk) begin
        if (do_wr) mem_q[cnt_q[IW-1:0]] <= wr_data;
    end

    assign rd_data = (rd_idx < FULL) ? mem_q[rd_idx] : '0;
    assign count   = cnt_q;
endmodule

// File: rtl/tx_crc32.sv
// Serial CRC-32, one bit per enable, LSB-first (reflected) form of POLY.
// Assumes init and en are never high together; crc_o is the inverted register.
module tx_crc32 #(
    parameter logic [31:0] POLY = 32'h04C11DB7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic        din,
    output logic [31:0] crc_o
);
    function automatic logic [31:0] mirror32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    localparam logic [31:0] RPOLY = mirror32(POLY);

    logic [31:0] reg_q;
    logic        fb;

    assign fb = reg_q[0] ^ din;

    // Preset on init, shift one message bit in on each enable.
    always_ff @(posedge clk) begin
        if (!rst_n || init) reg_q <= '1;
        else if (en)        reg_q <= (reg_q >> 1) ^ (fb ? RPOLY : 32'h0);
    end

    assign crc_o = ~reg_q;
endmodule

// File: rtl/bmc_msg_tx.sv
// Biphase mark message transmitter: sends preamble, header, stored objects and CRC-32,
// LSB first, then a tail bit that leaves the line low before releasing it.
// Assumes HALF_BIT_CYC >= 2 and a 3-bit object count field at CNT_LSB of the header.
module bmc_msg_tx
    import bmc_tx_pkg::*;
#(
    parameter int HALF_BIT_CYC = 333,
    parameter int PRE_BITS     = 64,
    parameter int MAX_OBJ      = 7,
    parameter int CNT_LSB      = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        obj_wr,
    input  logic [31:0] obj_data,
    input  logic        start,
    input  logic [15:0] header,
    output logic        line_o,
    output logic        line_oe,
    output logic        busy,
    output logic        done,
    output logic        start_err
);
    localparam int NW  = $clog2(MAX_OBJ + 1);
    localparam int BCW = $clog2((PRE_BITS > OBJ_BITS) ? PRE_BITS : OBJ_BITS);
    localparam logic [BCW-1:0] PRE_LAST = BCW'(PRE_BITS - 1);
    localparam logic [BCW-1:0] HDR_LAST = BCW'(HDR_BITS - 1);
    localparam logic [BCW-1:0] OBJ_LAST = BCW'(OBJ_BITS - 1);
    localparam logic [BCW-1:0] CRC_LAST = BCW'(CRC_BITS - 1);

    phase_t            phase_q;
    logic [BCW-1:0]    bcnt_q;
    logic              half_q;
    logic              lvl_q;
    logic [15:0]       hdr_q;
    logic [NW-1:0]     nobj_q;
    logic [NW-1:0]     oidx_q;
    logic              done_q;
    logic              err_q;

    logic              running;
    logic              tick;
    logic              accept;
    logic              count_ok;
    logic              cur_bit;
    logic              bit_end;
    logic              crc_en;
    logic [NW-1:0]     stored;
    logic [31:0]       obj_word;
    logic [31:0]       crc_val;

    assign running  = (phase_q != PH_IDLE);
    assign count_ok = (header[CNT_LSB +: NW] == stored);
    assign accept   = start && !running && count_ok;
    assign bit_end  = tick && half_q && (phase_q != PH_TAIL);
    assign crc_en   = bit_end && ((phase_q == PH_HDR) || (phase_q == PH_OBJ));

    tx_halfbit_timer #(.HALF_CYC(HALF_BIT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .tick  (tick)
    );

    tx_obj_buffer #(.MAX_OBJ(MAX_OBJ), .WIDTH(OBJ_BITS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (obj_wr && !running),
        .wr_data (obj_data),
        .clr     (accept),
        .rd_idx  (oidx_q),
        .rd_data (obj_word),
        .count   (stored)
    );

    tx_crc32 #(.POLY(32'h04C11DB7)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (accept),
        .en    (crc_en),
        .din   (cur_bit),
        .crc_o (crc_val)
    );

    // Select the data bit for the current bit period from the active field.
    always_comb begin
        unique case (phase_q)
            PH_PRE:  cur_bit = bcnt_q[0];
            PH_HDR:  cur_bit = hdr_q[bcnt_q[3:0]];
            PH_OBJ:  cur_bit = obj_word[bcnt_q[4:0]];
            PH_CRC:  cur_bit = crc_val[bcnt_q[4:0]];
            default: cur_bit = 1'b0;
        endcase
    end

    // Frame sequencer and line level: boundary toggles, mid-bit toggles, tail and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            bcnt_q  <= '0;
            half_q  <= 1'b0;
            lvl_q   <= 1'b0;
            hdr_q   <= '0;
            nobj_q  <= '0;
            oidx_q  <= '0;
        end else if (accept) begin
            phase_q <= PH_PRE;
            bcnt_q  <= '0;
            half_q  <= 1'b0;
            lvl_q   <= 1'b1;
            hdr_q   <= header;
            nobj_q  <= header[CNT_LSB +: NW];
            oidx_q  <= '0;
        end else if (tick) begin
            if (!half_q) begin
                half_q <= 1'b1;
                if (phase_q == PH_TAIL) lvl_q <= 1'b0;
                else if (cur_bit)       lvl_q <= ~lvl_q;
            end else begin
                half_q <= 1'b0;
                lvl_q  <= ~lvl_q;
                unique case (phase_q)
                    PH_PRE: begin
                        if (bcnt_q == PRE_LAST) begin
                            phase_q <= PH_HDR;
                            bcnt_q  <= '0;
                        end else begin
                            bcnt_q <= bcnt_q + 1'b1;
                        end
                    end
                    PH_HDR: begin
                        if (bcnt_q == HDR_LAST) begin
                            phase_q <= (nobj_q == '0) ? PH_CRC : PH_OBJ;
                            bcnt_q  <= '0;
                            oidx_q  <= '0;
                        end else begin
                            bcnt_q <= bcnt_q + 1'b1;
                        end
                    end
                    PH_OBJ: begin
                        if (bcnt_q == OBJ_LAST) begin
                            bcnt_q <= '0;
                            if ((oidx_q + NW'(1)) == nobj_q) phase_q <= PH_CRC;
                            else                             oidx_q  <= oidx_q + NW'(1);
                        end else begin
                            bcnt_q <= bcnt_q + 1'b1;
                        end
                    end
                    PH_CRC: begin
                        if (bcnt_q == CRC_LAST) begin
                            phase_q <= PH_TAIL;
                            bcnt_q  <= '0;
                        end else begin
                            bcnt_q <= bcnt_q + 1'b1;
                        end
                    end
                    PH_TAIL: begin
                        phase_q <= PH_IDLE;
                        lvl_q   <= 1'b0;
                    end
                    default: phase_q <= PH_IDLE;
                endcase
            end
        end
    end

    // One-cycle pulses for the end of a frame and for a refused start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= tick && half_q && (phase_q == PH_TAIL);
            err_q  <= start && !accept;
        end
    end

    assign line_o    = lvl_q;
    assign line_oe   = running;
    assign busy      = running;
    assign done      = done_q;
    assign start_err = err_q;
endmodule

// File: rtl/bmc_msg_tx_chk.sv
// Property checker for the message transmitter, bound to every instance of the top.
// Assumes slot timing starts on the first cycle the enable is high.
module bmc_msg_tx_chk #(
    parameter int HALF_BIT_CYC = 333
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic line_o,
    input logic line_oe,
    input logic busy,
    input logic done,
    input logic start_err
);
    localparam int SW = $clog2(HALF_BIT_CYC + 1);

    logic [SW-1:0] slot_q;

    // Independent half-bit slot position, counted from the rise of the enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !line_oe)                 slot_q <= '0;
        else if (slot_q == SW'(HALF_BIT_CYC-1)) slot_q <= '0;
        else                                    slot_q <= slot_q + 1'b1;
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !line_oe |-> (!line_o && !busy)); // R1

    AST_EDGE_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && $past(line_oe) && (line_o != $past(line_o))) |-> (slot_q == '0)); // R2

    AST_REFUSE_IDLE_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (start_err && !$past(busy)) |-> !line_oe); // R5

    AST_REFUSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> start_err); // R6

    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!line_oe && !line_o && $past(line_oe))); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
endmodule

bind bmc_msg_tx bmc_msg_tx_chk #(.HALF_BIT_CYC(HALF_BIT_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .line_o    (line_o),
    .line_oe   (line_oe),
    .busy      (busy),
    .done      (done),
    .start_err (start_err)
);

// File: tb/tb_bmc_msg_tx.sv
`timescale 1ns/1ps
module tb_bmc_msg_tx;
    localparam int H = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        obj_wr = 1'b0;
    logic [31:0] obj_data = '0;
    logic        start = 1'b0;
    logic [15:0] header = '0;
    logic        line_o, line_oe, busy, done, start_err;

    always #2.5 clk = ~clk;

    bmc_msg_tx #(.HALF_BIT_CYC(H)) dut (
        .clk(clk), .rst_n(rst_n), .obj_wr(obj_wr), .obj_data(obj_data),
        .start(start), .header(header), .line_o(line_o), .line_oe(line_oe),
        .busy(busy), .done(done), .start_err(start_err)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Vector table: {header, object seed}; object count is header[14:12].
    localparam logic [47:0] VEC [0:3] = '{
        {16'h0041, 32'h00000000},
        {16'h1A5C, 32'hFFFFFFFF},
        {16'hAF0F, 32'h00000000},
        {16'h7ABC, 32'h13579BDF}
    };

    logic [31:0] objs [0:7];

    // Line capture at the falling edge while the driver is enabled.
    logic samp [0:4095];
    int   ns = 0;
    int   n_done = 0;
    logic prev_oe = 1'b0;

    always @(negedge clk) begin
        if (line_oe) begin
            if (!prev_oe) begin
                ns = 1;
                samp[0] = line_o;
            end else begin
                if (ns < 4096) samp[ns] = line_o;
                ns++;
            end
        end
        if (done) n_done++;
        prev_oe = line_oe;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual cycle %0d expected end before it", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
        return c;
    endfunction

    task automatic write_obj(input logic [31:0] w);
        @(negedge clk);
        obj_wr = 1'b1;
        obj_data = w;
        @(negedge clk);
        obj_wr = 1'b0;
    endtask

    // Check the last captured frame against header and the first n bench objects.
    task automatic check_frame(input logic [15:0] hdr, input int n, input string tag);
        logic eb [0:511];
        logic hv [0:1023];
        int nb = 0;
        logic [31:0] c = 32'hFFFFFFFF;
        logic [31:0] crc_exp, crc_got;
        int bad_slot = -1, bad_bnd = -1, bad_bit = -1;
        logic prev;
        for (int k = 0; k < 64; k++) begin eb[nb] = k[0]; nb++; end
        for (int k = 0; k < 16; k++) begin eb[nb] = hdr[k]; c = crc_step(c, hdr[k]); nb++; end
        for (int j = 0; j < n; j++)
            for (int k = 0; k < 32; k++) begin
                eb[nb] = objs[j][k]; c = crc_step(c, objs[j][k]); nb++;
            end
        crc_exp = ~c;
        for (int k = 0; k < 32; k++) begin eb[nb] = crc_exp[k]; nb++; end

        chk(ns == (nb + 1) * 2 * H, "R7", {tag, " frame length incl. tail"}, ns, (nb + 1) * 2 * H);
        if (ns != (nb + 1) * 2 * H) return;

        for (int k = 0; k < 2 * nb + 2; k++) begin
            hv[k] = samp[k * H + 1];
            for (int s = 0; s < H; s++)
                if (samp[k * H + s] != samp[k * H] && bad_slot < 0) bad_slot = k;
        end
        prev = 1'b0;
        crc_got = '0;
        for (int i = 0; i < nb; i++) begin
            if (hv[2 * i] == prev && bad_bnd < 0) bad_bnd = i;
            if ((hv[2 * i] ^ hv[2 * i + 1]) != eb[i] && bad_bit < 0 && i < nb - 32) bad_bit = i;
            if (i >= nb - 32) crc_got[i - (nb - 32)] = hv[2 * i] ^ hv[2 * i + 1];
            prev = hv[2 * i + 1];
        end
        chk(bad_slot < 0, "R2", {tag, " slot held constant, first bad slot"}, bad_slot, -1);
        chk(bad_bnd < 0, "R2", {tag, " toggle at every bit start, first bad bit"}, bad_bnd, -1);
        chk(bad_bit < 0, "R3", {tag, " preamble/header/object bits, first bad bit"}, bad_bit, -1);
        chk(crc_got == crc_exp, "R4", {tag, " crc"}, crc_got, crc_exp);
        chk(hv[2 * nb] != prev && hv[2 * nb + 1] == 1'b0, "R7", {tag, " tail halves"},
            {hv[2 * nb], hv[2 * nb + 1]}, {~prev, 1'b0});
    endtask

    // Start a frame, verify acceptance, wait for done and check done and release.
    task automatic send(input logic [15:0] hdr, input int n, input string tag);
        int d0;
        int t;
        d0 = n_done;
        @(negedge clk);
        start = 1'b1;
        header = hdr;
        @(negedge clk);
        start = 1'b0;
        chk(busy && line_oe && line_o && !start_err, "R2", {tag, " accepted, first level high"},
            {busy, line_oe, line_o, start_err}, 4'b1110);
        t = 0;
        while (n_done == d0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        chk(n_done == d0 + 1 && !busy && !line_oe && !line_o && !done, "R7",
            {tag, " single done then released"}, n_done - d0, 1);
        check_frame(hdr, n, tag);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!line_oe && !line_o && !busy && !done && !start_err, "R1", "state in reset",
            {line_oe, line_o, busy, done, start_err}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!line_oe && !line_o && !busy && !done, "R1", "idle after reset",
            {line_oe, line_o, busy, done}, 0);

        // Table-driven frames.
        for (int v = 0; v < 4; v++) begin
            logic [15:0] hdr;
            int n;
            hdr = VEC[v][47:32];
            n = int'(hdr[14:12]);
            for (int j = 0; j < n; j++) begin
                objs[j] = VEC[v][31:0] + 32'(j) * 32'h9E3779B9;
                if (VEC[v][31:0] == 32'hFFFFFFFF) objs[j] = 32'hFFFFFFFF;
                write_obj(objs[j]);
            end
            send(hdr, n, $sformatf("vec%0d", v));
        end

        // R5: count field mismatch is refused, line stays released.
        objs[0] = 32'hCAFEF00D;
        objs[1] = 32'h0BADBEEF;
        write_obj(objs[0]);
        write_obj(objs[1]);
        @(negedge clk);
        start = 1'b1;
        header = 16'h3123;
        @(negedge clk);
        start = 1'b0;
        chk(start_err && !busy && !line_oe, "R5", "mismatched count refused",
            {start_err, busy, line_oe}, 3'b100);
        @(negedge clk);
        chk(!start_err && !line_oe, "R5", "refusal pulse one cycle", {start_err, line_oe}, 0);
        send(16'h2123, 2, "R5 matching count");

        // R6 and R8: start and writes during a frame are refused or ignored.
        @(negedge clk);
        start = 1'b1;
        header = 16'h0ABC;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        start = 1'b1;
        header = 16'h1FFF;
        obj_wr = 1'b1;
        obj_data = 32'h55555555;
        @(negedge clk);
        start = 1'b0;
        obj_wr = 1'b0;
        chk(start_err && busy, "R6", "start while busy refused", {start_err, busy}, 2'b11);
        write_obj(32'h66666666);
        begin
            int t = 0;
            while (line_oe && t < 20000) begin @(negedge clk); t++; end
        end
        @(negedge clk);
        check_frame(16'h0ABC, 0, "R6 running frame unchanged");
        send(16'h0F0F, 0, "R8 writes during frame ignored");

        // R8: writes past seven are ignored.
        for (int j = 0; j < 9; j++) begin
            logic [31:0] w;
            w = 32'hA5000000 + 32'(j) * 32'h00010203;
            if (j < 8) objs[j] = w;
            write_obj(w);
        end
        send(16'h7001, 7, "R8 store limit");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule